// File: doc/BRIEF.md
# Request-Paced Single-Channel DMA Engine with Continuous Mode

This block is one DMA channel that copies items from a source address to a destination address. A peripheral request line paces the copying. Software starts the channel with a control write. That write carries the item count, the item size, a fixed-or-increment choice for each address, and a continuous-run flag. Each item is a read on a valid/ready memory port, then a write of the returned data.

The count is held as N-1 in a 10-bit field, so one programming moves between 1 and 1024 items. With the continuous flag clear, the channel stops and pulses `xfer_done` after the last item. With the flag set, the count rests at zero and the channel keeps serving the request line until software writes the enable low. An incrementing address in this mode runs past the programmed buffer and wraps modulo the address width. Keeping the buffer in range is up to software.

The controller has five states:
- `S_IDLE` moves to `S_WAIT` on a control write with enable high.
- `S_WAIT` moves to `S_IDLE` if a stop is pending. Otherwise it moves to `S_RD_REQ` while `dma_req` is high.
- `S_RD_REQ` moves to `S_RD_WAIT` when the read is accepted.
- `S_RD_WAIT` moves to `S_WR_REQ` when the read data returns.
- `S_WR_REQ` moves on when the write is accepted. It goes to `S_IDLE` with a done pulse if the count is zero and the continuous flag is clear. Otherwise it goes back to `S_WAIT`.

Top module: `dmach_top`

## Requirements
- R1: After reset, `busy` is 0, `bus_valid` is 0 and `xfer_done` is 0.
- R2: With the continuous flag clear, a count field of k moves exactly k+1 items. `xfer_done` is then high for one cycle and `busy` falls.
- R3: No read is requested while `dma_req` is low. Lowering the request pauses the channel, and raising it again resumes it.
- R4: Each item is one read accepted by `bus_ready`, then a wait for `bus_rvalid`, then a write of the returned data to the destination address. The next read waits until that write is accepted.
- R5: Size code 0 (byte) steps an incrementing address by 1, code 1 (halfword) by 2, and code 2 (word) by 4. Code 3 is treated as word.
- R6: An address programmed as fixed keeps its base value for every item.
- R7: With the continuous flag set, transfers go on past a zero count for as long as `dma_req` stays high, and no done pulse is raised.
- R8: A control write with enable low while the channel is active stops it at the next item boundary. `busy` falls, every issued read has its write, and no done pulse is raised.
- R9: An incrementing address wraps modulo 2^ADDR_W.
- R10: A control write with enable high while the channel is active reloads only the remaining count.
- R11: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_we`, `bus_addr` and `bus_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable bit of the control write |
| ctl_cont | input | 1 | Continuous-run flag |
| ctl_src_inc | input | 1 | 1: source increments, 0: fixed |
| ctl_dst_inc | input | 1 | 1: destination increments, 0: fixed |
| ctl_size | input | 2 | Item size code (0 byte, 1 half, 2/3 word) |
| ctl_count | input | CNT_W | Item count minus one |
| src_base | input | ADDR_W | Source start address |
| dst_base | input | ADDR_W | Destination start address |
| dma_req | input | 1 | Peripheral request |
| bus_valid | output | 1 | Memory request valid |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Memory address |
| bus_size | output | 2 | Item size code of the access |
| bus_wdata | output | DATA_W | Write data |
| bus_ready | input | 1 | Memory accepts request |
| bus_rvalid | input | 1 | Read data valid |
| bus_rdata | input | DATA_W | Read data |
| busy | output | 1 | Channel active |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs the continuous mode over many items. A design that stopped at the zero count would go idle early or raise a stray done pulse.

It places a manual stop in the middle of a stalled transfer. A design that dropped out between the read and the write would leave a read with no write.

It starts a source at the top of the address space. A design that saturated the address instead of wrapping would repeat the last address.

It also covers three more cases:
- It holds the request low after programming. A design that ignored pacing would issue reads.
- It rewrites the count while the channel waits. A design that ignored the rewrite would move the old number of items.
- It tries all size codes. A wrong step would show up as wrong addresses.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT,
        S_RD_REQ,
        S_RD_WAIT,
        S_WR_REQ
    } ch_state_e;

    // size code 3 is treated as word
    function automatic logic [1:0] eff_shift(input logic [1:0] sz);
        return (sz == 2'd3) ? 2'd2 : sz;
    endfunction

endpackage

// File: rtl/dmach_addr.sv
module dmach_addr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              inc_en,
    input  logic [1:0]        shift,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr
);

    logic inc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr  <= '0;
            inc_q <= 1'b0;
        end else if (load) begin
            addr  <= base;
            inc_q <= inc_en;
        end else if (advance && inc_q) begin
            addr <= addr + (ADDR_W'(1) << shift);   // wraps modulo 2^ADDR_W
        end
    end

    // R6: a fixed address never moves between loads
    p_fixed_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !inc_q) |=> $stable(addr));

endmodule

// File: rtl/dmach_count.sv
module dmach_count #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] value,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= value;
        else if (dec && (cnt != '0))
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R7: a zero count rests at zero instead of wrapping
    p_cnt_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && zero) |=> zero);

    // R2: without a reload the count never grows
    p_cnt_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load) |=> (cnt <= $past(cnt)));

endmodule

// File: rtl/dmach_fsm.sv
module dmach_fsm
    import dmach_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_we,
    input  logic ctl_en,
    input  logic ctl_cont,
    input  logic dreq,
    input  logic bus_ready,
    input  logic bus_rvalid,
    input  logic cnt_zero,
    output logic cfg_load,
    output logic cnt_reload,
    output logic item_done,
    output logic capture,
    output logic bus_valid,
    output logic bus_we,
    output logic busy,
    output logic done
);

    ch_state_e state;
    logic      cont_q;
    logic      stop_q;
    logic      done_q;

    // state register and transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            cont_q <= 1'b0;
            stop_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state != S_IDLE && ctl_we && !ctl_en)
                stop_q <= 1'b1;
            unique case (state)
                S_IDLE: begin
                    if (ctl_we && ctl_en) begin
                        state  <= S_WAIT;
                        cont_q <= ctl_cont;
                        stop_q <= 1'b0;
                    end
                end
                S_WAIT: begin
                    if (stop_q)
                        state <= S_IDLE;
                    else if (dreq)
                        state <= S_RD_REQ;
                end
                S_RD_REQ: begin
                    if (bus_ready)
                        state <= S_RD_WAIT;
                end
                S_RD_WAIT: begin
                    if (bus_rvalid)
                        state <= S_WR_REQ;
                end
                S_WR_REQ: begin
                    if (bus_ready) begin
                        if (cnt_zero && !cont_q) begin
                            state  <= S_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            state <= S_WAIT;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        cfg_load   = (state == S_IDLE) && ctl_we && ctl_en;
        cnt_reload = (state != S_IDLE) && ctl_we && ctl_en;
        bus_valid  = (state == S_RD_REQ) || (state == S_WR_REQ);
        bus_we     = (state == S_WR_REQ);
        capture    = (state == S_RD_WAIT) && bus_rvalid;
        item_done  = (state == S_WR_REQ) && bus_ready;
        busy       = (state != S_IDLE);
        done       = done_q;
    end

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_pace_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && !dreq) |=> !bus_valid);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_we)));

    p_stop_nodone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && stop_q) |=> (!done && !busy));

    p_cont_nodone_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cont_q) |=> !done);

endmodule

// File: rtl/dmach_top.sv
module dmach_top
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              ctl_en,
    input  logic              ctl_cont,
    input  logic              ctl_src_inc,
    input  logic              ctl_dst_inc,
    input  logic [1:0]        ctl_size,
    input  logic [CNT_W-1:0]  ctl_count,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic              dma_req,
    output logic              bus_valid,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ready,
    input  logic              bus_rvalid,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              xfer_done
);

    localparam int SIDES = 2;   // 0 source, 1 destination

    logic              cfg_load, cnt_reload, item_done, capture, cnt_zero;
    logic [1:0]        size_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] side_addr [SIDES];

    dmach_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_en     (ctl_en),
        .ctl_cont   (ctl_cont),
        .dreq       (dma_req),
        .bus_ready  (bus_ready),
        .bus_rvalid (bus_rvalid),
        .cnt_zero   (cnt_zero),
        .cfg_load   (cfg_load),
        .cnt_reload (cnt_reload),
        .item_done  (item_done),
        .capture    (capture),
        .bus_valid  (bus_valid),
        .bus_we     (bus_we),
        .busy       (busy),
        .done       (xfer_done)
    );

    dmach_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cfg_load || cnt_reload),
        .value (ctl_count),
        .dec   (item_done),
        .zero  (cnt_zero)
    );

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        dmach_addr #(.ADDR_W(ADDR_W)) u_addr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (cfg_load),
            .base    ((g == 0) ? src_base : dst_base),
            .inc_en  ((g == 0) ? ctl_src_inc : ctl_dst_inc),
            .shift   (eff_shift(size_q)),
            .advance (item_done),
            .addr    (side_addr[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= 2'd0;
            data_q <= '0;
        end else begin
            if (cfg_load)
                size_q <= ctl_size;
            if (capture)
                data_q <= bus_rdata;
        end
    end

    assign bus_addr  = bus_we ? side_addr[1] : side_addr[0];
    assign bus_size  = size_q;
    assign bus_wdata = data_q;

    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> ($stable(bus_addr) && $stable(bus_wdata)));

endmodule

// File: tb/test_dmach_top.sv
module test_dmach_top;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 10;
    localparam int LOGN = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_we = 1'b0, ctl_en = 1'b0, ctl_cont = 1'b0;
    logic          ctl_src_inc = 1'b0, ctl_dst_inc = 1'b0;
    logic [1:0]    ctl_size = 2'd0;
    logic [CW-1:0] ctl_count = '0;
    logic [AW-1:0] src_base = '0, dst_base = '0;
    logic          dma_req = 1'b0;
    logic          bus_valid, bus_we, busy, xfer_done;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size;
    logic [DW-1:0] bus_wdata;
    logic          bus_ready = 1'b0, bus_rvalid = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    always #2 clk = ~clk;   // 250 MHz

    dmach_top i_dmach_top (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_cont(ctl_cont),
        .ctl_src_inc(ctl_src_inc), .ctl_dst_inc(ctl_dst_inc), .ctl_size(ctl_size),
        .ctl_count(ctl_count), .src_base(src_base), .dst_base(dst_base), .dma_req(dma_req),
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .busy(busy), .xfer_done(xfer_done)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    int nr = 0, nw = 0, n_done = 0, n_viol = 0;
    logic [AW-1:0] rd_addr [LOGN];
    logic [AW-1:0] wr_addr [LOGN];
    logic [DW-1:0] wr_data [LOGN];
    logic          rd_pend = 1'b0;
    logic [AW-1:0] rd_a = '0;
    logic          stall = 1'b0;
    logic          p_stall = 1'b0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_wdata = '0;
    logic          p_we = 1'b0;

    function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    // memory responder: drive on falling edge
    always @(negedge clk) begin
        bus_ready  <= !stall || (cyc % 3 == 2);
        bus_rvalid <= rd_pend;
        bus_rdata  <= mem_val(rd_a);
    end

    // monitor on rising edge
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (p_stall && !(bus_valid && bus_we == p_we && bus_addr == p_addr && bus_wdata == p_wdata))
                n_viol = n_viol + 1;
            p_stall = bus_valid && !bus_ready;
            p_addr = bus_addr; p_we = bus_we; p_wdata = bus_wdata;
            if (xfer_done) n_done = n_done + 1;
            if (bus_rvalid) rd_pend = 1'b0;
            if (bus_valid && bus_ready) begin
                if (bus_we) begin
                    if (nw < LOGN) begin wr_addr[nw] = bus_addr; wr_data[nw] = bus_wdata; end
                    nw = nw + 1;
                end else begin
                    if (nr < LOGN) rd_addr[nr] = bus_addr;
                    nr = nr + 1;
                    rd_pend = 1'b1;
                    rd_a = bus_addr;
                end
            end
        end
        if (cyc == 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual cycles %0d expected completion earlier", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic prog(input bit en, input bit cont, input bit si, input bit di,
                        input logic [1:0] sz, input int cnt, input logic [AW-1:0] s,
                        input logic [AW-1:0] d);
        @(negedge clk);
        ctl_we = 1'b1; ctl_en = en; ctl_cont = cont; ctl_src_inc = si; ctl_dst_inc = di;
        ctl_size = sz; ctl_count = CW'(cnt); src_base = s; dst_base = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic clear_log();
        @(negedge clk);
        nr = 0; nw = 0; n_done = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_items(input int n);
        for (int i = 0; i < 5000 && nw < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy, "R1 busy", busy, 0);
        chk(!bus_valid, "R1 bus_valid", bus_valid, 0);
        chk(!xfer_done, "R1 done", xfer_done, 0);
    endtask

    task automatic t_basic();
        clear_log();
        dma_req = 1'b1;
        prog(1, 0, 1, 0, 2'd2, 3, 32'h100, 32'h2000);
        wait_idle();
        chk(nw == 4, "R2 item count", nw, 4);
        chk(n_done == 1, "R2 done pulses", n_done, 1);
        chk(!busy, "R2 busy after", busy, 0);
        for (int i = 0; i < 4; i++) begin
            chk(rd_addr[i] == 32'h100 + 4 * i, "R5 word src step", rd_addr[i], 32'h100 + 4 * i);
            chk(wr_addr[i] == 32'h2000, "R6 fixed dst", wr_addr[i], 32'h2000);
            chk(wr_data[i] == mem_val(rd_addr[i]), "R4 data moved", wr_data[i], mem_val(rd_addr[i]));
        end
        dma_req = 1'b0;
    endtask

    task automatic t_sizes();
        clear_log();
        dma_req = 1'b1;
        prog(1, 0, 1, 1, 2'd0, 2, 32'h10, 32'h80);
        wait_idle();
        chk(nw == 3, "R5 byte count", nw, 3);
        for (int i = 0; i < 3; i++)
            chk(wr_addr[i] == 32'h80 + i, "R5 byte dst step", wr_addr[i], 32'h80 + i);
        clear_log();
        prog(1, 0, 1, 1, 2'd1, 2, 32'h20, 32'h90);
        wait_idle();
        for (int i = 0; i < 3; i++)
            chk(rd_addr[i] == 32'h20 + 2 * i, "R5 half src step", rd_addr[i], 32'h20 + 2 * i);
        clear_log();
        prog(1, 0, 1, 1, 2'd3, 1, 32'h40, 32'hA0);
        wait_idle();
        chk(rd_addr[1] == 32'h44, "R5 code3 as word", rd_addr[1], 32'h44);
        chk(wr_addr[1] == 32'hA4, "R5 code3 dst", wr_addr[1], 32'hA4);
        dma_req = 1'b0;
    endtask

    task automatic t_pace();
        clear_log();
        dma_req = 1'b0;
        prog(1, 0, 1, 0, 2'd2, 2, 32'h300, 32'h3000);
        repeat (20) @(negedge clk);
        chk(nr == 0, "R3 no read without request", nr, 0);
        chk(busy, "R3 still active", busy, 1);
        dma_req = 1'b1;
        wait_idle();
        chk(nw == 3, "R3 resumes to finish", nw, 3);
        chk(n_done == 1, "R2 done after pacing", n_done, 1);
        dma_req = 1'b0;
    endtask

    task automatic t_cont();
        int n0;
        clear_log();
        dma_req = 1'b1;
        prog(1, 1, 1, 0, 2'd2, 1, 32'h400, 32'h3000);
        wait_items(8);
        chk(nw >= 8, "R7 runs past count", nw, 8);
        chk(busy, "R7 still busy", busy, 1);
        chk(n_done == 0, "R7 no done", n_done, 0);
        dma_req = 1'b0;
        repeat (10) @(negedge clk);
        n0 = nw;
        repeat (20) @(negedge clk);
        chk(nw == n0, "R3 paused on request low", nw, n0);
        chk(busy, "R7 waits while request low", busy, 1);
        prog(0, 0, 0, 0, 2'd0, 0, 0, 0);
        wait_idle();
        chk(!busy, "R8 stopped", busy, 0);
        chk(n_done == 0, "R8 no done on stop", n_done, 0);
        for (int i = 0; i < nw && i < LOGN; i++)
            chk(rd_addr[i] == 32'h400 + 4 * i, "R7 src keeps stepping", rd_addr[i], 32'h400 + 4 * i);
    endtask

    task automatic t_wrap();
        clear_log();
        dma_req = 1'b1;
        prog(1, 1, 1, 1, 2'd2, 0, 32'hFFFF_FFF8, 32'hFFFF_FFFC);
        wait_items(4);
        dma_req = 1'b0;
        repeat (10) @(negedge clk);
        prog(0, 0, 0, 0, 2'd0, 0, 0, 0);
        wait_idle();
        chk(rd_addr[2] == 32'h0, "R9 src wraps", rd_addr[2], 0);
        chk(rd_addr[3] == 32'h4, "R9 src after wrap", rd_addr[3], 4);
        chk(wr_addr[1] == 32'h0, "R9 dst wraps", wr_addr[1], 0);
    endtask

    task automatic t_stop_mid();
        clear_log();
        stall = 1'b1;
        dma_req = 1'b1;
        prog(1, 0, 1, 1, 2'd0, 20, 32'h500, 32'h600);
        wait_items(3);
        prog(0, 0, 0, 0, 2'd0, 0, 0, 0);
        wait_idle();
        chk(!busy, "R8 stopped mid run", busy, 0);
        chk(nw < 21, "R8 stopped early", nw, 20);
        chk(nw == nr, "R8 item boundary", nw, nr);
        chk(n_done == 0, "R8 no done mid stop", n_done, 0);
        stall = 1'b0;
        dma_req = 1'b0;
    endtask

    task automatic t_reload();
        clear_log();
        dma_req = 1'b0;
        prog(1, 0, 1, 0, 2'd2, 1, 32'h700, 32'h3000);
        prog(1, 0, 0, 1, 2'd0, 4, 32'h0, 32'h0);   // only count may change
        dma_req = 1'b1;
        wait_idle();
        chk(nw == 5, "R10 reloaded count", nw, 5);
        chk(rd_addr[1] == 32'h704, "R10 addresses kept", rd_addr[1], 32'h704);
        chk(n_done == 1, "R10 done once", n_done, 1);
        dma_req = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_basic();
        t_sizes();
        t_pace();
        t_cont();
        t_wrap();
        t_stop_mid();
        t_reload();
        chk(n_viol == 0, "R11 request held while stalled", n_viol, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule